// File: doc/BRIEF.md
# Fuse Shadow and Signature Controller

This block sits between a small microcontroller's stored configuration fuses and the logic that uses them. It keeps a working copy of the fuse bits, called the effective vector, which the rest of the chip reads. It decides when that copy is refreshed from the stored array. While the part is in programming mode, the working copy is frozen. Fuse writes land in the stored array only, and they take effect when programming mode ends. The one exception is the data-preserve fuse bit, which follows a new write at once.

The block also serves a small read-only identification space. Each address holds a low byte, which is one of three identification values, and a high byte. The high byte of address zero carries the stored oscillator calibration byte. On every reset, that stored byte is copied into the oscillator calibration register. Software may overwrite the register afterwards. Reset also models a power-up of a blank part: the stored fuses come up erased, and the effective vector captures them.

Top module: `fuse_sig_ctrl`

## Requirements
- R1: After reset, `eff_fuse` is all ones (erased, active-low encoding where 0 means programmed), `cal_reg` equals the stored calibration byte (parameter `CAL_STORED`, default 0xA7), and `rd_valid` is 0.
- R2: A `fuse_wr` pulse while `prog_mode` is low is ignored: the stored fuses keep their value, so a later pass through programming mode leaves `eff_fuse` unchanged.
- R3: While `prog_mode` stays high, every bit of `eff_fuse` except the preserve bit holds its value, even after `fuse_wr` pulses change the stored fuses.
- R4: A `fuse_wr` pulse in programming mode sets bit `PRESERVE_BIT` (default 3) of `eff_fuse` to the written bit on the next cycle.
- R5: In the first cycle that samples `prog_mode` low after it was high, the whole effective vector is reloaded from the stored fuses, and the new value is visible one cycle later.
- R6: In the first cycle that samples `prog_mode` high, the effective vector is captured from the stored fuses.
- R7: A read accepted with `rd_en` returns its data one cycle later with `rd_valid` high. The low byte of addresses 0x000, 0x001 and 0x002 is 0x1E, 0x94 and 0x05, in that order.
- R8: The high byte (`rd_hi` = 1) of address 0x000 returns the stored calibration byte, not the current value of `cal_reg`.
- R9: Every other address/byte pair returns 0xFF, and `rd_valid` is 0 in any cycle that does not follow an `rd_en`.
- R10: A `cal_wr` pulse loads `cal_reg` with `cal_wdata` on the next cycle. A later reset restores the stored calibration byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| prog_mode | input | 1 | Level, high while programming mode is active |
| fuse_wr | input | 1 | Single-cycle stored-fuse write strobe |
| fuse_wdata | input | FUSE_W | New stored fuse value (0 = programmed) |
| cal_wr | input | 1 | Software write strobe for the calibration register |
| cal_wdata | input | 8 | Software value for the calibration register |
| rd_en | input | 1 | Read request for the identification space |
| rd_addr | input | ADDR_W | Identification-space address |
| rd_hi | input | 1 | 1 selects the high byte, 0 the low byte |
| eff_fuse | output | FUSE_W | Effective fuse vector seen by the core |
| cal_reg | output | 8 | Oscillator calibration register |
| rd_data | output | 8 | Read data |
| rd_valid | output | 1 | Read data valid |

## Verification
The fuse path is driven with three kinds of write: a write outside programming mode, a write that clears the preserve bit among other bits, and a write that sets only the preserve bit. The first separates an ignored write from a stored one. The other two separate the bit that applies at once from the bits that wait for the exit edge. The read path walks the three identification bytes, the calibration high byte, a high byte at a nonzero address and an address at the top of the range. A software overwrite of the calibration register checks that reads still return the stored byte and that reset restores it.

// File: rtl/fsc_pkg.sv
package fsc_pkg;

    typedef enum logic [1:0] {
        PM_IDLE,
        PM_ENTER,
        PM_HOLD,
        PM_EXIT
    } pm_event_e;

    typedef struct packed {
        logic       valid;
        logic [7:0] data;
    } rd_resp_t;

    localparam int         SIG_COUNT = 3;
    localparam logic [7:0] BLANK_BYTE = 8'hFF;

    function automatic logic [7:0] sig_id_byte(input int unsigned idx);
        case (idx)
            0:       return 8'h1E;
            1:       return 8'h94;
            2:       return 8'h05;
            default: return BLANK_BYTE;
        endcase
    endfunction

    function automatic pm_event_e classify_mode(input logic now_on, input logic was_on);
        case ({was_on, now_on})
            2'b01:   return PM_ENTER;
            2'b11:   return PM_HOLD;
            2'b10:   return PM_EXIT;
            default: return PM_IDLE;
        endcase
    endfunction

    function automatic logic [7:0] sig_lookup(input logic [31:0] addr, input logic hi,
                                              input logic [7:0] cal);
        if (hi) begin
            return (addr == 32'd0) ? cal : BLANK_BYTE;
        end
        if (addr < SIG_COUNT) begin
            return sig_id_byte(addr);
        end
        return BLANK_BYTE;
    endfunction

endpackage

// File: rtl/fsc_shadow.sv
module fsc_shadow
    import fsc_pkg::*;
#(
    parameter int FUSE_W       = 16,
    parameter int PRESERVE_BIT = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              prog_mode,
    input  logic              fuse_wr,
    input  logic [FUSE_W-1:0] fuse_wdata,
    output logic [FUSE_W-1:0] eff_fuse,
    output logic [FUSE_W-1:0] stored_fuse
);

    localparam logic [FUSE_W-1:0] ERASED = '1;

    logic      prog_q;
    logic      wr_ok;
    pm_event_e ev;

    assign wr_ok = fuse_wr && prog_mode;
    assign ev    = classify_mode(prog_mode, prog_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            prog_q      <= 1'b0;
            stored_fuse <= ERASED;
            eff_fuse    <= ERASED;
        end else begin
            prog_q <= prog_mode;
            if (wr_ok) begin
                stored_fuse <= fuse_wdata;
            end
            if (ev == PM_ENTER || ev == PM_EXIT) begin
                eff_fuse <= stored_fuse;
            end
            if (wr_ok) begin
                eff_fuse[PRESERVE_BIT] <= fuse_wdata[PRESERVE_BIT];
            end
        end
    end

endmodule

// File: rtl/fsc_sig_rd.sv
module fsc_sig_rd
    import fsc_pkg::*;
#(
    parameter int         ADDR_W     = 10,
    parameter logic [7:0] CAL_STORED = 8'hA7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_hi,
    output rd_resp_t          resp
);

    always_ff @(posedge clk) begin
        if (rst) begin
            resp <= '{valid: 1'b0, data: BLANK_BYTE};
        end else begin
            resp.valid <= rd_en;
            if (rd_en) begin
                resp.data <= sig_lookup(32'(rd_addr), rd_hi, CAL_STORED);
            end
        end
    end

endmodule

// File: rtl/fsc_cal.sv
module fsc_cal #(
    parameter logic [7:0] CAL_STORED = 8'hA7
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cal_wr,
    input  logic [7:0] cal_wdata,
    output logic [7:0] cal_reg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cal_reg <= CAL_STORED;
        end else if (cal_wr) begin
            cal_reg <= cal_wdata;
        end
    end

endmodule

// File: rtl/fuse_sig_ctrl.sv
module fuse_sig_ctrl
    import fsc_pkg::*;
#(
    parameter int         FUSE_W       = 16,
    parameter int         PRESERVE_BIT = 3,
    parameter int         ADDR_W       = 10,
    parameter logic [7:0] CAL_STORED   = 8'hA7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              prog_mode,
    input  logic              fuse_wr,
    input  logic [FUSE_W-1:0] fuse_wdata,
    input  logic              cal_wr,
    input  logic [7:0]        cal_wdata,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_hi,
    output logic [FUSE_W-1:0] eff_fuse,
    output logic [7:0]        cal_reg,
    output logic [7:0]        rd_data,
    output logic              rd_valid
);

    logic [FUSE_W-1:0] stored_fuse;
    rd_resp_t          resp;

    fsc_shadow #(
        .FUSE_W      (FUSE_W),
        .PRESERVE_BIT(PRESERVE_BIT)
    ) shadow_i (
        .clk        (clk),
        .rst        (rst),
        .prog_mode  (prog_mode),
        .fuse_wr    (fuse_wr),
        .fuse_wdata (fuse_wdata),
        .eff_fuse   (eff_fuse),
        .stored_fuse(stored_fuse)
    );

    fsc_sig_rd #(
        .ADDR_W    (ADDR_W),
        .CAL_STORED(CAL_STORED)
    ) sig_i (
        .clk    (clk),
        .rst    (rst),
        .rd_en  (rd_en),
        .rd_addr(rd_addr),
        .rd_hi  (rd_hi),
        .resp   (resp)
    );

    fsc_cal #(
        .CAL_STORED(CAL_STORED)
    ) cal_i (
        .clk      (clk),
        .rst      (rst),
        .cal_wr   (cal_wr),
        .cal_wdata(cal_wdata),
        .cal_reg  (cal_reg)
    );

    assign rd_data  = resp.data;
    assign rd_valid = resp.valid;

endmodule

// File: rtl/fsc_chk.sv
module fsc_chk #(
    parameter int         FUSE_W       = 16,
    parameter int         PRESERVE_BIT = 3,
    parameter logic [7:0] CAL_STORED   = 8'hA7
) (
    input logic              clk,
    input logic              rst,
    input logic              prog_mode,
    input logic              fuse_wr,
    input logic [FUSE_W-1:0] fuse_wdata,
    input logic [FUSE_W-1:0] eff_fuse,
    input logic [FUSE_W-1:0] stored_fuse,
    input logic [7:0]        cal_reg,
    input logic              rd_en,
    input logic              rd_valid
);

    localparam logic [FUSE_W-1:0] HOLD_MASK = ~(FUSE_W'(1) << PRESERVE_BIT);

    assert_cal_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cal_reg == CAL_STORED && eff_fuse == '1));

    assert_ignore_write_R2: assert property (@(posedge clk) disable iff (rst)
        (fuse_wr && !prog_mode) |=> $stable(stored_fuse));

    assert_frozen_R3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && prog_mode && $past(prog_mode)) |=> $stable(eff_fuse & HOLD_MASK));

    assert_preserve_now_R4: assert property (@(posedge clk) disable iff (rst)
        (fuse_wr && prog_mode) |=> eff_fuse[PRESERVE_BIT] == $past(fuse_wdata[PRESERVE_BIT]));

    assert_exit_reload_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !prog_mode && $past(prog_mode)) |=> eff_fuse == stored_fuse);

    assert_read_valid_R9: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid);

endmodule

bind fuse_sig_ctrl fsc_chk #(
    .FUSE_W      (FUSE_W),
    .PRESERVE_BIT(PRESERVE_BIT),
    .CAL_STORED  (CAL_STORED)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .prog_mode  (prog_mode),
    .fuse_wr    (fuse_wr),
    .fuse_wdata (fuse_wdata),
    .eff_fuse   (eff_fuse),
    .stored_fuse(stored_fuse),
    .cal_reg    (cal_reg),
    .rd_en      (rd_en),
    .rd_valid   (rd_valid)
);

// File: tb/fuse_sig_ctrl_tb_top.sv
module fuse_sig_ctrl_tb_top;

    localparam int         FUSE_W = 16;
    localparam int         ADDR_W = 10;
    localparam logic [7:0] CAL    = 8'hA7;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              prog_mode = 1'b0;
    logic              fuse_wr = 1'b0;
    logic [FUSE_W-1:0] fuse_wdata = '0;
    logic              cal_wr = 1'b0;
    logic [7:0]        cal_wdata = '0;
    logic              rd_en = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic              rd_hi = 1'b0;
    logic [FUSE_W-1:0] eff_fuse;
    logic [7:0]        cal_reg;
    logic [7:0]        rd_data;
    logic              rd_valid;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    fuse_sig_ctrl #(
        .FUSE_W      (FUSE_W),
        .PRESERVE_BIT(3),
        .ADDR_W      (ADDR_W),
        .CAL_STORED  (CAL)
    ) dut_i (
        .clk(clk), .rst(rst), .prog_mode(prog_mode), .fuse_wr(fuse_wr),
        .fuse_wdata(fuse_wdata), .cal_wr(cal_wr), .cal_wdata(cal_wdata),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_hi(rd_hi), .eff_fuse(eff_fuse),
        .cal_reg(cal_reg), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    // {addr, hi, expected byte}
    localparam logic [18:0] RD_VEC [8] = '{
        {10'h000, 1'b0, 8'h1E},
        {10'h001, 1'b0, 8'h94},
        {10'h002, 1'b0, 8'h05},
        {10'h000, 1'b1, CAL},
        {10'h003, 1'b0, 8'hFF},
        {10'h001, 1'b1, 8'hFF},
        {10'h3FF, 1'b0, 8'hFF},
        {10'h002, 1'b1, 8'hFF}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected under 5000", cycles);
            finish_run();
        end
    end

    initial begin
        tick(); tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        check("R1 eff", 32'(eff_fuse), 32'hFFFF);
        check("R1 cal", 32'(cal_reg), 32'(CAL));
        check("R1 valid", 32'(rd_valid), 32'd0);

        // R7 R8 R9 table of reads
        for (int i = 0; i < 8; i++) begin
            rd_en   = 1'b1;
            rd_addr = RD_VEC[i][18:9];
            rd_hi   = RD_VEC[i][8];
            tick();
            check("R7 valid", 32'(rd_valid), 32'd1);
            check(RD_VEC[i][8] ? "R8 R9 data" : "R7 R9 data", 32'(rd_data), 32'(RD_VEC[i][7:0]));
        end
        rd_en = 1'b0;
        tick();
        check("R9 idle valid", 32'(rd_valid), 32'd0);

        // R2 write outside programming mode ignored
        fuse_wr = 1'b1; fuse_wdata = 16'h0000;
        tick();
        fuse_wr = 1'b0;
        check("R2 eff unchanged", 32'(eff_fuse), 32'hFFFF);
        prog_mode = 1'b1;
        tick();
        prog_mode = 1'b0;
        tick();
        tick();
        check("R2 after pass", 32'(eff_fuse), 32'hFFFF);

        // R6 entry capture, R3 freeze, R4 preserve bit
        prog_mode = 1'b1;
        tick();
        check("R6 entry", 32'(eff_fuse), 32'hFFFF);
        fuse_wr = 1'b1; fuse_wdata = 16'h1234;
        tick();
        fuse_wr = 1'b0;
        check("R4 R3 preserve cleared", 32'(eff_fuse), 32'hFFF7);
        tick(); tick();
        check("R3 still frozen", 32'(eff_fuse), 32'hFFF7);
        prog_mode = 1'b0;
        tick();
        check("R5 reload", 32'(eff_fuse), 32'h1234);

        // R6 entry again, preserve set alone
        prog_mode = 1'b1;
        tick();
        check("R6 entry captured", 32'(eff_fuse), 32'h1234);
        fuse_wr = 1'b1; fuse_wdata = 16'h0008;
        tick();
        fuse_wr = 1'b0;
        check("R4 preserve set", 32'(eff_fuse), 32'h123C);
        prog_mode = 1'b0;
        tick();
        check("R5 reload second", 32'(eff_fuse), 32'h0008);

        // R10 software overwrite, then reset reload
        cal_wr = 1'b1; cal_wdata = 8'h55;
        tick();
        cal_wr = 1'b0;
        check("R10 overwrite", 32'(cal_reg), 32'h55);
        rd_en = 1'b1; rd_addr = '0; rd_hi = 1'b1;
        tick();
        rd_en = 1'b0;
        check("R8 stored not live", 32'(rd_data), 32'(CAL));
        rst = 1'b1;
        tick();
        rst = 1'b0;
        tick();
        check("R10 reset reload", 32'(cal_reg), 32'(CAL));
        check("R1 eff after reset", 32'(eff_fuse), 32'hFFFF);

        finish_run();
    end

endmodule